// File: doc/BRIEF.md
# Self-Test Step Sequence Checker

This block watches the self-test steps that an analog converter starts and confirms that they arrive in the required order. There are three test algorithms, named S, RC and C, and they run in that rotation. Within each algorithm the steps count upward from zero. Algorithm S always has three steps. The step counts of RC and C are parameters of up to eight each. After the last step of C, the rotation returns to step 0 of S.

Step starts can come from the converter's own scan sequencer or from an external trigger unit. Trigger-unit numbers are checked only in burst mode. Nothing is checked outside scan mode.

An out-of-order start sets a sticky error. While the error is set, a critical-fault output is raised, and an interrupt is raised when its enable allows it. After an error, the tracker takes the observed step as its new position, so a single slip produces only one error.

Three kinds of repeated step are handled differently:
- A step cut short by a chain abort and then repeated counts as an error.
- A step cut short by an injected conversion may be repeated freely.
- A chain abort during the last step of S sends the tracker back to step 0 of S, because that algorithm restarts from the beginning.

Top module: `step_seq_checker`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), seq_err, crit_fault and irq are 0, and the tracker expects algorithm S step 0.
- R2: A start is checked when step_vld=1, scan_mode=1, and either src_trig=0 or burst_mode=1. Algorithm codes are S=0, RC=1, C=2. Starts in the order S0..S2, RC0..RC(RC_STEPS-1), C0..C(C_STEPS-1), and then back to S0, never set seq_err, for any number of rounds.
- R3: A checked start that differs from the expected step sets seq_err at the next clock edge. seq_err then stays set until err_clr is high at an edge. A new error in the same cycle as err_clr takes precedence, and seq_err stays 1.
- R4: crit_fault equals seq_err. irq equals seq_err AND irq_en; it is combinational in irq_en.
- R5: A chain_abort is applied while a step is active, meaning it was started and not yet ended by step_done or an abort. If that step is not S step 2 and it is then started again, seq_err is set.
- R6: A chain_abort while S step 2 is active returns the expected step to S step 0. The following S0 start is not an error.
- R7: An inj_abort while a step is active sets the expected step back to that step. Repeating it is not an error.
- R8: When src_trig=1 and burst_mode=0, step starts are ignored. They neither flag errors nor move the tracker.
- R9: When scan_mode=0, step starts are ignored. They neither flag errors nor move the tracker.
- R10: After a flagged error on a valid step, the expected step becomes the successor of the observed step.
- R11: A start with algorithm code 3, or with a step number at or above that algorithm's step count, flags an error. The expected step then returns to S step 0.
- R12: Aborts arriving when no step is active are ignored. A step start in the same cycle as an abort takes precedence, and the abort is dropped. If chain_abort and inj_abort arrive together, chain_abort wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_mode | input | 1 | 1 = scan mode; checking enabled |
| src_trig | input | 1 | 1 = step numbers come from the trigger unit |
| burst_mode | input | 1 | Trigger unit runs in burst mode |
| step_vld | input | 1 | One-cycle step-start event |
| step_alg | input | 2 | Algorithm code of the started step (S=0, RC=1, C=2) |
| step_num | input | 3 | Step number within the algorithm |
| step_done | input | 1 | The active step finished normally |
| chain_abort | input | 1 | The chain was aborted during the active step |
| inj_abort | input | 1 | An injected conversion aborted the active step |
| irq_en | input | 1 | Interrupt enable for the sequence error |
| err_clr | input | 1 | Clears the sticky error |
| seq_err | output | 1 | Sticky sequence error |
| crit_fault | output | 1 | Critical fault, raised while the error is set |
| irq | output | 1 | Maskable interrupt |

## Verification
The assertions assume the following about the inputs:
- step_vld, step_done and the abort inputs are single-cycle pulses.
- Mode inputs change only between events.
- The only source of a new error is a checked step start.

The assertions that state a mode stays quiet therefore also assume that err_clr does not interfere in that cycle. The bench drives every pulse for exactly one cycle on the falling edge and changes modes only while idle. It sweeps every algorithm code and step number against every position in a full rotation.

// File: rtl/sqc_pkg.sv
// Shared constants and types for the step sequence checker.
// Assumes at most MAX_STEPS steps per algorithm.
package sqc_pkg;
    localparam int MAX_STEPS = 8;
    localparam int STEP_W    = $clog2(MAX_STEPS);
    localparam int LEN_W     = STEP_W + 1;
    localparam int S_STEPS   = 3;

    typedef enum logic [1:0] {
        ALG_S    = 2'd0,
        ALG_RC   = 2'd1,
        ALG_C    = 2'd2,
        ALG_NONE = 2'd3
    } alg_e;

    typedef struct packed {
        alg_e              alg;
        logic [STEP_W-1:0] num;
    } step_t;

    // Algorithm that follows a given one in the test rotation.
    function automatic alg_e next_alg(input alg_e a);
        case (a)
            ALG_S:   return ALG_RC;
            ALG_RC:  return ALG_C;
            default: return ALG_S;
        endcase
    endfunction
endpackage

// File: rtl/sqc_len_rom.sv
// Step-count lookup per algorithm code.
// The unused code 3 reports length 0, so every step number is out of range for it.
module sqc_len_rom
    import sqc_pkg::*;
#(
    parameter int RC_STEPS = 4,
    parameter int C_STEPS  = 5
) (
    input  alg_e             alg,
    output logic [LEN_W-1:0] len
);
    logic [LEN_W-1:0] tab [4];

    // One table entry per algorithm code.
    for (genvar g = 0; g < 4; g++) begin : g_len
        localparam int L = (g == 0) ? S_STEPS :
                           (g == 1) ? RC_STEPS :
                           (g == 2) ? C_STEPS : 0;
        assign tab[g] = LEN_W'(L);
    end

    assign len = tab[alg];
endmodule

// File: rtl/sqc_tracker.sv
// Expected-step tracker.
// Compares each checked start with the expected step, then moves to the successor
// of the observed step. Also keeps the active step so that aborts can rewind it.
// Assumes ev, step_done and the aborts are single-cycle pulses.
module sqc_tracker
    import sqc_pkg::*;
#(
    parameter int RC_STEPS = 4,
    parameter int C_STEPS  = 5
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ev,
    input  step_t obs,
    input  logic  step_done,
    input  logic  chain_abort,
    input  logic  inj_abort,
    output logic  err_ev,
    output step_t exp_st
);
    localparam step_t S_ZERO = '{alg: ALG_S, num: '0};

    logic [LEN_W-1:0] obs_len;
    logic             obs_valid;
    logic             obs_last;
    step_t            obs_next;
    step_t            exp_q;
    step_t            act_q;
    logic             act_vld_q;
    logic             act_s_last;

    sqc_len_rom #(.RC_STEPS(RC_STEPS), .C_STEPS(C_STEPS)) u_len (
        .alg (obs.alg),
        .len (obs_len)
    );

    // Classify the observed step and form its successor.
    always_comb begin
        obs_valid = (obs.alg != ALG_NONE) && ({1'b0, obs.num} < obs_len);
        obs_last  = ({1'b0, obs.num} == obs_len - LEN_W'(1));
        if (!obs_valid)
            obs_next = S_ZERO;
        else if (obs_last)
            obs_next = '{alg: next_alg(obs.alg), num: '0};
        else
            obs_next = '{alg: obs.alg, num: obs.num + STEP_W'(1)};
    end

    assign act_s_last = (act_q.alg == ALG_S) && (act_q.num == STEP_W'(S_STEPS - 1));
    assign err_ev     = ev && (obs != exp_q);
    assign exp_st     = exp_q;

    // Advance on checked starts; rewind or release the active step on aborts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q     <= S_ZERO;
            act_q     <= S_ZERO;
            act_vld_q <= 1'b0;
        end else if (ev) begin
            exp_q     <= obs_next;
            act_q     <= obs;
            act_vld_q <= obs_valid;
        end else if (act_vld_q) begin
            if (chain_abort) begin
                act_vld_q <= 1'b0;
                if (act_s_last)
                    exp_q <= S_ZERO;
            end else if (inj_abort) begin
                act_vld_q <= 1'b0;
                exp_q     <= act_q;
            end else if (step_done) begin
                act_vld_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sqc_flags.sv
// Sticky sequence-error flag and the outputs derived from it.
// A new error in the same cycle as a clear keeps the flag set.
module sqc_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic err_ev,
    input  logic err_clr,
    input  logic irq_en,
    output logic seq_err,
    output logic crit_fault,
    output logic irq
);
    logic err_q;

    // Set on an error event, clear on request; the error has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (err_ev)
            err_q <= 1'b1;
        else if (err_clr)
            err_q <= 1'b0;
    end

    assign seq_err    = err_q;
    assign crit_fault = err_q;
    assign irq        = err_q & irq_en;
endmodule

// File: rtl/step_seq_checker.sv
// Top of the self-test step sequence checker.
// Qualifies step starts by scan mode and source (trigger-unit starts only in burst
// mode), tracks the expected step and drives the error outputs.
// Assumes the step count parameters lie in 1..MAX_STEPS.
module step_seq_checker
    import sqc_pkg::*;
#(
    parameter int RC_STEPS = 4,
    parameter int C_STEPS  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_mode,
    input  logic              src_trig,
    input  logic              burst_mode,
    input  logic              step_vld,
    input  logic [1:0]        step_alg,
    input  logic [STEP_W-1:0] step_num,
    input  logic              step_done,
    input  logic              chain_abort,
    input  logic              inj_abort,
    input  logic              irq_en,
    input  logic              err_clr,
    output logic              seq_err,
    output logic              crit_fault,
    output logic              irq
);
    logic  chk_ev;
    logic  err_ev;
    step_t obs;
    step_t exp_st;

    // Only scan-mode starts from the sequencer, or from a bursting trigger unit, are checked.
    assign chk_ev = step_vld && scan_mode && (!src_trig || burst_mode);
    assign obs    = '{alg: alg_e'(step_alg), num: step_num};

    sqc_tracker #(.RC_STEPS(RC_STEPS), .C_STEPS(C_STEPS)) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev          (chk_ev),
        .obs         (obs),
        .step_done   (step_done),
        .chain_abort (chain_abort),
        .inj_abort   (inj_abort),
        .err_ev      (err_ev),
        .exp_st      (exp_st)
    );

    sqc_flags u_flg (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_ev     (err_ev),
        .err_clr    (err_clr),
        .irq_en     (irq_en),
        .seq_err    (seq_err),
        .crit_fault (crit_fault),
        .irq        (irq)
    );
endmodule

// File: rtl/sqc_checker.sv
// Assertion checker for step_seq_checker, attached by bind.
// Assumes single-cycle pulses and that only checked starts create errors.
module sqc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scan_mode,
    input logic       src_trig,
    input logic       burst_mode,
    input logic       step_vld,
    input logic       err_clr,
    input logic       irq_en,
    input logic       seq_err,
    input logic       crit_fault,
    input logic       irq,
    input logic [1:0] exp_alg
);
    AST_RESET_CLEAN: assert property (@(posedge clk) !rst_n |=> !seq_err && !crit_fault); // R1
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) seq_err && !err_clr |=> seq_err); // R3
    AST_RISE_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n) $rose(seq_err) |-> $past(step_vld)); // R3
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) !irq_en |-> !irq); // R4
    AST_IRQ_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n) irq |-> crit_fault); // R4
    AST_NONBURST_QUIET: assert property (@(posedge clk) disable iff (!rst_n) src_trig && !burst_mode && !seq_err |=> !seq_err); // R8
    AST_ONESHOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !scan_mode && !seq_err |=> !seq_err); // R9
    AST_EXP_VALID: assert property (@(posedge clk) disable iff (!rst_n) exp_alg != 2'd3); // R11
endmodule

bind step_seq_checker sqc_checker u_sqc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_mode  (scan_mode),
    .src_trig   (src_trig),
    .burst_mode (burst_mode),
    .step_vld   (step_vld),
    .err_clr    (err_clr),
    .irq_en     (irq_en),
    .seq_err    (seq_err),
    .crit_fault (crit_fault),
    .irq        (irq),
    .exp_alg    (exp_st.alg)
);

// File: tb/step_seq_checker_bench.sv
// Self-checking bench: directed cases per requirement plus a sweep of every
// algorithm/step code against every position of a full rotation.
module step_seq_checker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RC_N  = 4;
    localparam int C_N   = 5;
    localparam int TOTAL = 3 + RC_N + C_N;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_mode = 1'b1, src_trig = 1'b0, burst_mode = 1'b0;
    logic step_vld = 1'b0;
    logic [1:0] step_alg = '0;
    logic [2:0] step_num = '0;
    logic step_done = 1'b0, chain_abort = 1'b0, inj_abort = 1'b0;
    logic irq_en = 1'b1, err_clr = 1'b0;
    logic seq_err, crit_fault, irq;
    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    step_seq_checker #(.RC_STEPS(RC_N), .C_STEPS(C_N)) u_step_seq_checker (
        .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .src_trig(src_trig),
        .burst_mode(burst_mode), .step_vld(step_vld), .step_alg(step_alg),
        .step_num(step_num), .step_done(step_done), .chain_abort(chain_abort),
        .inj_abort(inj_abort), .irq_en(irq_en), .err_clr(err_clr),
        .seq_err(seq_err), .crit_fault(crit_fault), .irq(irq)
    );

    function automatic int alen(input int a);
        return (a == 0) ? 3 : (a == 1) ? RC_N : (a == 2) ? C_N : 0;
    endfunction

    function automatic int pos_alg(input int k);
        return (k < 3) ? 0 : (k < 3 + RC_N) ? 1 : 2;
    endfunction

    function automatic int pos_num(input int k);
        return (k < 3) ? k : (k < 3 + RC_N) ? k - 3 : k - 3 - RC_N;
    endfunction

    task automatic chk(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; scan_mode = 1'b1; src_trig = 1'b0; burst_mode = 1'b0;
        irq_en = 1'b1; err_clr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input int a, input int s);
        @(negedge clk);
        step_vld = 1'b1; step_alg = 2'(a); step_num = 3'(s);
        @(negedge clk);
        step_vld = 1'b0;
    endtask

    task automatic done();
        @(negedge clk); step_done = 1'b1;
        @(negedge clk); step_done = 1'b0;
    endtask

    task automatic clear();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got no finish expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 seq_err", seq_err, 1'b0);
        chk("R1 crit_fault", crit_fault, 1'b0);
        chk("R1 irq", irq, 1'b0);
        step(0, 0);
        chk("R1 expects S0", seq_err, 1'b0);

        // R2 two clean rounds
        do_reset();
        for (int r = 0; r < 2; r++)
            for (int k = 0; k < TOTAL; k++) begin
                step(pos_alg(k), pos_num(k));
                done();
                chk("R2 ordered round", seq_err, 1'b0);
            end

        // R3 sticky, clear, error beats clear
        do_reset();
        step(0, 1);
        chk("R3 set", seq_err, 1'b1);
        repeat (3) @(negedge clk);
        chk("R3 sticky", seq_err, 1'b1);
        clear();
        chk("R3 cleared", seq_err, 1'b0);
        @(negedge clk);
        err_clr = 1'b1; step_vld = 1'b1; step_alg = 2'd0; step_num = 3'd0;
        @(negedge clk);
        err_clr = 1'b0; step_vld = 1'b0;
        chk("R3 error wins over clear", seq_err, 1'b1);

        // R4 fault and interrupt masking
        irq_en = 1'b0; #1;
        chk("R4 crit_fault", crit_fault, 1'b1);
        chk("R4 irq masked", irq, 1'b0);
        irq_en = 1'b1; #1;
        chk("R4 irq enabled", irq, 1'b1);

        // R5 repeat after chain abort
        do_reset();
        step(0, 0);
        @(negedge clk); chain_abort = 1'b1; @(negedge clk); chain_abort = 1'b0;
        step(0, 0);
        chk("R5 repeat after abort", seq_err, 1'b1);
        clear();
        step(0, 1);
        chk("R5 R10 resync", seq_err, 1'b0);

        // R6 abort in last step of S
        do_reset();
        step(0, 0); done(); step(0, 1); done(); step(0, 2);
        @(negedge clk); chain_abort = 1'b1; @(negedge clk); chain_abort = 1'b0;
        step(0, 0);
        chk("R6 restart S0", seq_err, 1'b0);
        step(0, 1);
        chk("R6 continue S1", seq_err, 1'b0);

        // R7 injected conversion repeat
        do_reset();
        step(0, 0); done(); step(0, 1);
        @(negedge clk); inj_abort = 1'b1; @(negedge clk); inj_abort = 1'b0;
        step(0, 1);
        chk("R7 repeat allowed", seq_err, 1'b0);
        step(0, 2);
        chk("R7 continue", seq_err, 1'b0);

        // R8 trigger-unit source
        do_reset();
        src_trig = 1'b1; burst_mode = 1'b1;
        step(0, 2);
        chk("R8 burst checked", seq_err, 1'b1);
        do_reset();
        src_trig = 1'b1; burst_mode = 1'b0;
        step(1, 3);
        chk("R8 non-burst ignored", seq_err, 1'b0);
        burst_mode = 1'b1;
        step(0, 0);
        chk("R8 tracker unmoved", seq_err, 1'b0);

        // R9 one-shot mode
        do_reset();
        scan_mode = 1'b0;
        step(2, 4);
        chk("R9 ignored", seq_err, 1'b0);
        scan_mode = 1'b1;
        step(0, 0);
        chk("R9 tracker unmoved", seq_err, 1'b0);

        // R11 invalid code
        do_reset();
        step(0, 0); done();
        step(3, 0);
        chk("R11 code 3", seq_err, 1'b1);
        clear();
        step(0, 0);
        chk("R11 back to S0", seq_err, 1'b0);

        // R12 stray aborts and same-cycle precedence
        do_reset();
        step(0, 0); done();
        @(negedge clk); inj_abort = 1'b1; @(negedge clk); inj_abort = 1'b0;
        step(0, 1);
        chk("R12 idle abort ignored", seq_err, 1'b0);
        @(negedge clk);
        step_vld = 1'b1; step_alg = 2'd0; step_num = 3'd2; inj_abort = 1'b1;
        @(negedge clk);
        step_vld = 1'b0; inj_abort = 1'b0;
        chk("R12 step accepted", seq_err, 1'b0);
        step(1, 0);
        chk("R12 step wins over abort", seq_err, 1'b0);

        // R3 R10 R11 sweep: every code at every rotation position
        for (int k = 0; k < TOTAL; k++)
            for (int a = 0; a < 4; a++)
                for (int s = 0; s < 8; s++) begin
                    automatic bit vld = (s < alen(a));
                    automatic bit hit = (a == pos_alg(k)) && (s == pos_num(k));
                    automatic int na = vld ? ((s == alen(a) - 1) ? (a + 1) % 3 : a) : 0;
                    automatic int ns = vld ? ((s == alen(a) - 1) ? 0 : s + 1) : 0;
                    do_reset();
                    for (int j = 0; j < k; j++) begin
                        step(pos_alg(j), pos_num(j));
                        done();
                    end
                    step(a, s);
                    chk(vld ? "R3 sweep compare" : "R11 sweep invalid", seq_err, !hit);
                    done();
                    clear();
                    step(na, ns);
                    chk("R10 sweep successor", seq_err, 1'b0);
                end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule